// File: doc/BRIEF.md
# Two-Strobe Parallel Result Read Port

This block is the device-side read port of an eight-channel acquisition core. It holds no results of its own: it takes the eight 18-bit channel results from the conversion sequencer and hands them to a host over a 16-bit data bus. Each channel needs two read strobes. The first strobe returns the upper sixteen bits of the result. The second returns the two low bits, right-aligned and padded with zeros. Channels go out in ascending order, so a full set takes sixteen strobes. The port also drives a flag that marks the first word of channel 1, which lets the host find its place in the sequence.

The host controls the port with an active-low chip select and an active-low read strobe. Both are asynchronous to the system clock and pass through two-flop synchronisers. There are two ways to drive them. The host can hold chip select low and pace the words with the read strobe, or it can tie the two lines together and use each combined pulse as one read. The bus data and the flag each have an enable output, and the pad ring turns these into three-state drivers. Each time the sequencer signals a new result set, the word pointer goes back to channel 1.

A three-state FSM tracks the synchronised strobes. Its states are `S_OFF` (chip select high, nothing driven), `S_ARMED` (chip select low, read high, only the flag driven) and `S_DRIVE` (both low, bus driven). Its transitions are:
- `S_OFF` to `S_ARMED`, when chip select falls while read is high.
- `S_OFF` to `S_DRIVE`, when both strobes are low (the tied strobe case). This counts as a read.
- `S_ARMED` to `S_DRIVE`, when the read strobe falls. This counts as a read.
- `S_DRIVE` to `S_ARMED`, when the read strobe rises.
- `S_DRIVE` or `S_ARMED` to `S_OFF`, when chip select rises.

A pin change reaches the outputs on the third rising clock edge after it: two synchroniser stages, then the state register.

Top module: `par_result_port`

## Requirements
- R1: The bus enable is high only in `S_DRIVE`, that is, only while both synchronised strobes are low. Whenever the enable is low, the bus data reads all zeros.
- R2: The first read after a restart presents bits [17:2] of channel 1 on bus bits [15:0].
- R3: The second read of a channel presents the channel's bits [1:0] on bus bits [1:0], with bus bits [15:2] at zero.
- R4: Successive reads walk through word indices 0 to 15. Word index w carries channel w/2+1: the upper part when w is even, the low part when w is odd. The sixteenth read presents bits [1:0] of channel 8.
- R5: The read after the sixteenth presents bits [17:2] of channel 1 again (the pointer wraps).
- R6: A new-set pulse puts the next read back at word index 0. If the pulse comes in the same cycle that a read is taken, that read presents word index 0 and the following read presents word index 1.
- R7: The first-data flag goes high on the read that presents word index 0 and goes low on the next read. The flag enable equals "chip select low"; while chip select is high, the flag reads 0.
- R8: When chip select rises, the bus enable and the flag enable both drop, even if the read strobe is still low.
- R9: With chip select and read tied together, each combined low pulse takes exactly one word.
- R10: Read-strobe pulses while chip select is high take no word and leave the pointer where it was.
- R11: After reset, the state is `S_OFF`: both enables are low, the bus reads zero and the pointer is at word index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| new_set | input | 1 | One-cycle pulse from the sequencer: a new result set is ready |
| res_flat | input | NCH*RW (144) | Channel results; channel k (from 0) at bits [k*RW +: RW] |
| bus_data | output | BW (16) | Word presented to the host bus |
| bus_oe | output | 1 | Drive enable for the data bus |
| first_flag | output | 1 | First-data flag value |
| first_oe | output | 1 | Drive enable for the first-data flag |

## Verification
A new-set pulse from the sequencer can arrive in the same clock cycle that the FSM enters `S_DRIVE` and takes a word. In that case the restart must take priority, and the word taken must be word 0, not the word the old pointer was on. The bench first moves the pointer to the middle of a set. It then lowers the read strobe and raises the new-set pulse exactly on the third edge after the strobe change, which is the edge where the read is taken. The check passes if the bus shows channel 1's upper bits with the flag high, and the next read shows channel 1's low bits.

// File: rtl/par_result_port_pkg.sv
package par_result_port_pkg;
    typedef enum logic [1:0] {
        S_OFF   = 2'd0,
        S_ARMED = 2'd1,
        S_DRIVE = 2'd2
    } port_state_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], async_in[b]};
        end
        assign sync_out[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/word_pointer.sv
module word_pointer #(
    parameter int NWORDS = 16,
    localparam int PW    = $clog2(NWORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          advance,
    output logic [PW-1:0] idx_now,
    output logic [PW-1:0] idx_q
);
    logic [PW-1:0] idx_next;

    assign idx_now = restart ? '0 : idx_q;

    always_comb begin
        idx_next = idx_now;
        if (advance) begin
            if (idx_now == PW'(NWORDS - 1)) idx_next = '0;
            else                            idx_next = idx_now + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_next;
    end
endmodule

// File: rtl/word_mux.sv
module word_mux #(
    parameter int NCH    = 8,
    parameter int RW     = 18,
    parameter int BW     = 16,
    localparam int LW    = RW - BW,
    localparam int PW    = $clog2(2 * NCH)
) (
    input  logic [NCH*RW-1:0] res_flat,
    input  logic [PW-1:0]     idx,
    output logic [BW-1:0]     word,
    output logic              is_first
);
    logic [RW-1:0] chan [NCH];

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        assign chan[k] = res_flat[k*RW +: RW];
    end

    logic [RW-1:0] sel;
    assign sel = chan[idx[PW-1:1]];

    always_comb begin
        if (idx[0]) word = {{(BW-LW){1'b0}}, sel[LW-1:0]};
        else        word = sel[RW-1:LW];
    end

    assign is_first = (idx == '0);
endmodule

// File: rtl/par_result_port.sv
module par_result_port
    import par_result_port_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int RW    = 18,
    parameter int BW    = 16,
    localparam int NWORDS = 2 * NCH,
    localparam int PW     = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              new_set,
    input  logic [NCH*RW-1:0] res_flat,
    output logic [BW-1:0]     bus_data,
    output logic              bus_oe,
    output logic              first_flag,
    output logic              first_oe
);
    logic [1:0] strobes_s;
    logic       cs_s, rd_s;

    strobe_sync #(.N(2), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_n, rd_n}),
        .sync_out (strobes_s)
    );
    assign cs_s = strobes_s[1];
    assign rd_s = strobes_s[0];

    port_state_t state, nxt;
    logic        take;
    logic [PW-1:0] idx_now, widx;
    logic [BW-1:0] mux_word;
    logic          mux_first;

    always_comb begin
        nxt = state;
        unique case (state)
            S_OFF:   if (!cs_s) nxt = rd_s ? S_ARMED : S_DRIVE;
            S_ARMED: if (cs_s) nxt = S_OFF;
                     else if (!rd_s) nxt = S_DRIVE;
            S_DRIVE: if (cs_s) nxt = S_OFF;
                     else if (rd_s) nxt = S_ARMED;
            default: nxt = S_OFF;
        endcase
    end

    assign take = (state != S_DRIVE) && (nxt == S_DRIVE);

    word_pointer #(.NWORDS(NWORDS)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (new_set),
        .advance (take),
        .idx_now (idx_now),
        .idx_q   (widx)
    );

    word_mux #(.NCH(NCH), .RW(RW), .BW(BW)) u_mux (
        .res_flat (res_flat),
        .idx      (idx_now),
        .word     (mux_word),
        .is_first (mux_first)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= nxt;
    end

    // output registers: word and flag captured when a read is taken
    logic [BW-1:0] word_q;
    logic          first_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            first_q <= 1'b0;
        end else if (take) begin
            word_q  <= mux_word;
            first_q <= mux_first;
        end
    end

    assign bus_oe     = (state == S_DRIVE);
    assign first_oe   = (state != S_OFF);
    assign bus_data   = bus_oe ? word_q : '0;
    assign first_flag = first_oe & first_q;
endmodule

// File: rtl/par_result_port_chk.sv
module par_result_port_chk #(
    parameter int BW = 16,
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          new_set,
    input logic [BW-1:0] bus_data,
    input logic          bus_oe,
    input logic          first_flag,
    input logic          first_oe,
    input logic [PW-1:0] ptr
);
    p_off_bus_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_data == '0));

    p_low_word_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_oe) && !ptr[0]) |-> (bus_data[BW-1:2] == '0));

    p_first_needs_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        first_flag |-> first_oe);

    p_first_at_word0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_oe) && first_flag) |-> (ptr == PW'(1)));

    p_restart_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(new_set) && !$rose(bus_oe)) |-> (ptr == '0));

    p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$rose(bus_oe) && !$past(new_set)) |-> $stable(ptr));

    p_drive_has_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(first_oe) |-> !bus_oe);
endmodule

bind par_result_port par_result_port_chk #(.BW(BW), .PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .new_set    (new_set),
    .bus_data   (bus_data),
    .bus_oe     (bus_oe),
    .first_flag (first_flag),
    .first_oe   (first_oe),
    .ptr        (widx)
);

// File: tb/par_result_port_test.sv
module par_result_port_test;
    localparam int NCH = 8;
    localparam int RW  = 18;
    localparam int BW  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic rd_n = 1'b1;
    logic new_set = 1'b0;
    logic [NCH*RW-1:0] res_flat;
    logic [BW-1:0] bus_data;
    logic bus_oe, first_flag, first_oe;

    logic [RW-1:0] res [NCH];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always_comb
        for (int k = 0; k < NCH; k++) res_flat[k*RW +: RW] = res[k];

    par_result_port uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .new_set(new_set),
        .res_flat(res_flat), .bus_data(bus_data), .bus_oe(bus_oe),
        .first_flag(first_flag), .first_oe(first_oe)
    );

    // vector: bit4 = tied strobes, bits3:0 = expected word index
    localparam logic [4:0] VEC [18] = '{
        5'h00, 5'h01, 5'h12, 5'h03, 5'h14, 5'h15, 5'h06, 5'h07, 5'h18,
        5'h09, 5'h1A, 5'h0B, 5'h0C, 5'h1D, 5'h0E, 5'h0F, 5'h10, 5'h01
    };

    function automatic logic [BW-1:0] exp_word(int w);
        logic [RW-1:0] r;
        r = res[w / 2];
        if (w % 2 == 1) return {14'b0, r[1:0]};
        return r[17:2];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic load_set(int seed);
        @(negedge clk);
        for (int k = 0; k < NCH; k++)
            res[k] = RW'(seed * 4099 + k * 18'h0A5B7 + (k << 16));
        new_set = 1'b1;
        @(negedge clk);
        new_set = 1'b0;
        wait_cyc(2);
    endtask

    // one read; samples while the word is on the bus, compares with index w
    task automatic do_read(bit tied, int w, string req);
        @(negedge clk);
        if (tied) begin
            cs_n = 1'b0; rd_n = 1'b0;
        end else begin
            cs_n = 1'b0;
            wait_cyc(4);
            @(negedge clk);
            rd_n = 1'b0;
        end
        wait_cyc(4);
        check({req, " bus_oe"}, 32'(bus_oe), 32'd1);
        check({req, " data"}, 32'(bus_data), 32'(exp_word(w)));
        check({req, " R7 first"}, 32'(first_flag), 32'(w == 0));
        @(negedge clk);
        if (tied) begin
            cs_n = 1'b1; rd_n = 1'b1;
            wait_cyc(4);
            check("R8 tied end bus_oe", 32'(bus_oe), 32'd0);
            check("R8 tied end first_oe", 32'(first_oe), 32'd0);
        end else begin
            rd_n = 1'b1;
            wait_cyc(4);
            check("R1 rd high bus_oe", 32'(bus_oe), 32'd0);
        end
    endtask

    initial begin
        for (int k = 0; k < NCH; k++) res[k] = '0;
        wait_cyc(3);
        // R11 reset state
        check("R11 bus_oe", 32'(bus_oe), 32'd0);
        check("R11 first_oe", 32'(first_oe), 32'd0);
        check("R11 bus_data", 32'(bus_data), 32'd0);
        check("R11 first_flag", 32'(first_flag), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(2);

        load_set(1);
        for (int i = 0; i < 18; i++) begin
            string tag;
            int w;
            w = int'(VEC[i][3:0]);
            if (i >= 16)           tag = "R5 wrap";
            else if (w == 0)       tag = "R2 ch1 upper";
            else if (w == 15)      tag = "R4 ch8 low";
            else if (w % 2 == 1)   tag = "R3 low word";
            else                   tag = "R4 order";
            if (VEC[i][4]) tag = {tag, " R9 tied"};
            do_read(VEC[i][4], w, tag);
        end

        // R1: chip select low, read high -> bus not driven, flag driven
        @(negedge clk); cs_n = 1'b0;
        wait_cyc(4);
        check("R1 armed bus_oe", 32'(bus_oe), 32'd0);
        check("R7 armed first_oe", 32'(first_oe), 32'd1);

        // R10: read pulses with chip select high are ignored
        @(negedge clk); cs_n = 1'b1;
        wait_cyc(4);
        check("R7 cs high first_flag", 32'(first_flag), 32'd0);
        for (int p = 0; p < 3; p++) begin
            @(negedge clk); rd_n = 1'b0;
            wait_cyc(4);
            check("R10 no drive", 32'(bus_oe), 32'd0);
            @(negedge clk); rd_n = 1'b1;
            wait_cyc(4);
        end
        do_read(1'b0, 2, "R10 pointer kept");

        // R8: chip select rises while read still low
        @(negedge clk); rd_n = 1'b0;
        wait_cyc(4);
        check("R4 next word", 32'(bus_data), 32'(exp_word(3)));
        @(negedge clk); cs_n = 1'b1;
        wait_cyc(4);
        check("R8 cs rise bus_oe", 32'(bus_oe), 32'd0);
        check("R8 cs rise first_oe", 32'(first_oe), 32'd0);
        @(negedge clk); rd_n = 1'b1;
        wait_cyc(4);

        // R6: new set mid-sequence restarts at word 0
        load_set(7);
        do_read(1'b0, 0, "R6 restart R2");
        do_read(1'b1, 1, "R6 restart R3");
        do_read(1'b0, 2, "R6 continue");

        // R6: restart in the same cycle the read is taken
        @(negedge clk); cs_n = 1'b0;
        wait_cyc(4);
        @(negedge clk); rd_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk); new_set = 1'b1;
        @(posedge clk);
        @(negedge clk); new_set = 1'b0;
        wait_cyc(3);
        check("R6 collision data", 32'(bus_data), 32'(exp_word(0)));
        check("R6 collision first R7", 32'(first_flag), 32'd1);
        @(negedge clk); rd_n = 1'b1;
        wait_cyc(4);
        do_read(1'b0, 1, "R6 after collision");
        check("R7 flag low after next read", 32'(first_flag), 32'd0);

        @(negedge clk); cs_n = 1'b1;
        wait_cyc(4);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule